// File: doc/BRIEF.md
# DRAM Parallel Test Mode Logic

This block is a behavioural model of the parallel bit-test feature inside one DRAM die. It samples the row strobe, column strobe and write enable on a clock, and sorts each row cycle by the strobe levels seen when the row strobe falls. If the column strobe and write enable are both already low when the row strobe falls, the cycle is a test entry. The die then latches a test state. In that state the low column bits CA0, CA1 and CA10 no longer select a location. Each access covers a group of eight one-bit locations.

In test mode a write copies the input bit into all eight locations of the group. A test read returns a single flag: high when the eight bits agree, low when any bit differs. A test read also takes more clock cycles than a normal read. The state is cleared by a refresh cycle that is not an entry. That is either a column-before-row refresh with write enable high, or a row cycle in which the column strobe never falls. Write enable must satisfy a setup window before the row strobe falls and a hold window after it, both counted in clock cycles, or the entry is not accepted.

Top module: `dram_ptest_top`

## Requirements
- R1: After reset, test_active_o and dq_oe_o are 0.
- R2: A cycle in which cas_n_i and we_n_i are low when ras_n_i falls sets test_active_o. For this, we_n_i must be low on at least WE_SETUP_CYC (default 2) rising edges before the edge that sees ras_n_i fall, and stay low on the WE_HOLD_CYC (default 3) edges after it.
- R3: If we_n_i has been low on fewer than WE_SETUP_CYC edges before the fall, the cycle is treated as a plain column-before-row refresh and test_active_o stays 0.
- R4: If we_n_i rises or ras_n_i rises before the hold window is complete, the entry is dropped and test_active_o stays 0.
- R5: test_active_o stays 1 across normal read and write cycles.
- R6: A column-before-row refresh with we_n_i high clears test_active_o.
- R7: A row cycle in which cas_n_i never falls while ras_n_i is low clears test_active_o when ras_n_i rises.
- R8: In normal mode, a write stores din_i at the location given by the row latched at the ras_n_i fall and the column present at the cas_n_i fall. The location index is row bits [1:0], CA10 and CA[3:0]. A read raises dq_oe_o NORM_LAT (default 3) edges after the edge that sees cas_n_i fall, and returns the stored bit.
- R9: In test mode a read raises dq_oe_o NORM_LAT+TEST_EXTRA (default 4) edges after the cas_n_i fall edge.
- R10: In test mode a write stores din_i at all eight locations that differ only in CA0, CA1 and CA10.
- R11: A test-mode read drives dq_o to 1 when all eight grouped bits are equal and to 0 when any bit differs. The values of CA0, CA1 and CA10 on the read have no effect.
- R12: dq_oe_o falls on the first edge that sees cas_n_i high, and dq_o holds its value while dq_oe_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | 11 | Multiplexed row and column address |
| din_i | input | 1 | Write data bit |
| dq_o | output | 1 | Read data, or equal/unequal flag in test mode |
| dq_oe_o | output | 1 | Read data valid |
| test_active_o | output | 1 | Test state latched |

## Verification
Some rules are checked by the assertions on every cycle. The test state can only rise on an edge where both write enable and the row strobe are low. The output can only be enabled while the column strobe is low, and enabling it needs at least two edges of low column strobe first. The read data cannot change while the output stays enabled. Other behaviour shows up only in the bench scenarios: the exact read latency in each mode, copying a test write to eight locations, the equal/unequal flag, and rejecting entries that miss the write-enable setup or hold window.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;
  localparam int unsigned GRP_N = 8;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_ENTRY = 2'd1,
    CYC_CBR   = 2'd2,
    CYC_ROW   = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/dram_ptest_strobe_dec.sv
module dram_ptest_strobe_dec
  import dram_ptest_pkg::*;
#(
  parameter int unsigned WE_SETUP_CYC = 2,
  parameter int unsigned WE_HOLD_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output logic ras_fall_o,
  output logic cas_acc_o,
  output logic test_active_o
);
  localparam int unsigned SU_W = $clog2(WE_SETUP_CYC + 1);
  localparam int unsigned HD_W = $clog2(WE_HOLD_CYC + 1);

  logic            ras_q, cas_q;
  logic [SU_W-1:0] we_cnt_q;
  logic [HD_W-1:0] hold_cnt_q;
  logic            pend_q, active_q, cas_seen_q;
  cyc_kind_e       kind_q, kind_d;
  logic            ras_rise;

  assign ras_fall_o = ras_q & ~ras_n_i;
  assign ras_rise   = ~ras_q & ras_n_i;
  assign cas_acc_o  = cas_q & ~cas_n_i & ~ras_n_i & ~ras_q;

  always_comb begin
    kind_d = CYC_NONE;
    if (ras_fall_o) begin
      if (cas_n_i) kind_d = CYC_ROW;
      else if (!we_n_i && int'(we_cnt_q) >= int'(WE_SETUP_CYC)) kind_d = CYC_ENTRY;
      else kind_d = CYC_CBR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_cnt_q <= '0;
    else if (we_n_i) we_cnt_q <= '0;
    else if (int'(we_cnt_q) < int'(WE_SETUP_CYC)) we_cnt_q <= we_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      active_q   <= 1'b0;
      hold_cnt_q <= '0;
      kind_q     <= CYC_NONE;
      cas_seen_q <= 1'b0;
    end else begin
      if (ras_fall_o) begin
        kind_q     <= kind_d;
        cas_seen_q <= 1'b0;
        if (kind_d == CYC_ENTRY) begin
          pend_q     <= 1'b1;
          hold_cnt_q <= '0;
        end else if (kind_d == CYC_CBR) begin
          active_q <= 1'b0;
        end
      end else if (pend_q) begin
        if (we_n_i || ras_n_i) begin
          pend_q   <= 1'b0;
          active_q <= 1'b0;
        end else if (int'(hold_cnt_q) + 1 >= int'(WE_HOLD_CYC)) begin
          pend_q   <= 1'b0;
          active_q <= 1'b1;
        end else begin
          hold_cnt_q <= hold_cnt_q + 1'b1;
        end
      end
      if (cas_acc_o) cas_seen_q <= 1'b1;
      if (ras_rise) begin
        kind_q <= CYC_NONE;
        // row cycle with no column strobe acts as exit refresh
        if (kind_q == CYC_ROW && !cas_seen_q) active_q <= 1'b0;
      end
    end
  end

  assign test_active_o = active_q;

  // R2
  entry_we_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(!we_n_i));
  // R2
  entry_ras_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(!ras_n_i));
endmodule

// File: rtl/dram_ptest_store.sv
module dram_ptest_store
  import dram_ptest_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned ROW_BITS = 2,
  parameter int unsigned COL_LO   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              row_ld_i,
  input  logic              col_ld_i,
  input  logic              wr_en_i,
  input  logic              wr_all_i,
  input  logic              din_i,
  output logic              rd_bit_o,
  output logic              grp_eq_o
);
  localparam int unsigned IDX_W = ROW_BITS + 1 + COL_LO;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]    mem_q;
  logic [ROW_BITS-1:0] row_q;
  logic [ADDR_W-1:0]   col_q;
  logic [GRP_N-1:0]    grp;

  function automatic logic [IDX_W-1:0] loc(input logic [ROW_BITS-1:0] r,
                                           input logic [ADDR_W-1:0] c);
    return {r, c[ADDR_W-1], c[COL_LO-1:0]};
  endfunction

  // member g of the group: g[2] -> CA10, g[1:0] -> CA1:CA0
  function automatic logic [IDX_W-1:0] mbr(input logic [ROW_BITS-1:0] r,
                                           input logic [ADDR_W-1:0] c,
                                           input logic [2:0] g);
    return {r, g[2], c[COL_LO-1:2], g[1:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (row_ld_i) row_q <= addr_i[ROW_BITS-1:0];
      if (col_ld_i) col_q <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_en_i) begin
      if (wr_all_i) begin
        for (int g = 0; g < int'(GRP_N); g++) mem_q[mbr(row_q, addr_i, 3'(g))] <= din_i;
      end else begin
        mem_q[loc(row_q, addr_i)] <= din_i;
      end
    end
  end

  for (genvar g = 0; g < int'(GRP_N); g++) begin : g_grp
    assign grp[g] = mem_q[mbr(row_q, col_q, 3'(g))];
  end

  assign rd_bit_o = mem_q[loc(row_q, col_q)];
  assign grp_eq_o = (&grp) | ~(|grp);
endmodule

// File: rtl/dram_ptest_rd_pipe.sv
module dram_ptest_rd_pipe #(
  parameter int unsigned NORM_LAT   = 3,
  parameter int unsigned TEST_EXTRA = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cas_n_i,
  input  logic start_i,
  input  logic test_i,
  input  logic rd_bit_i,
  input  logic grp_eq_i,
  output logic dq_o,
  output logic dq_oe_o
);
  // NORM_LAT must be at least 2
  localparam int unsigned MAX_LAT = NORM_LAT + TEST_EXTRA;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q, dq_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
      dq_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= test_i ? CNT_W'(MAX_LAT) : CNT_W'(NORM_LAT);
      mode_q <= test_i;
      oe_q   <= 1'b0;
    end else if (cas_n_i) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (cnt_q == CNT_W'(1)) begin
      cnt_q <= '0;
      oe_q  <= 1'b1;
      dq_q  <= mode_q ? grp_eq_i : rd_bit_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;

  // R12
  oe_needs_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> $past(!cas_n_i));
  // R8
  oe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> ($past(!cas_n_i) && $past(!cas_n_i, 2)));
  // R12
  dq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && $past(oe_q)) |-> $stable(dq_q));
endmodule

// File: rtl/dram_ptest_top.sv
module dram_ptest_top #(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned ROW_BITS     = 2,
  parameter int unsigned COL_LO       = 4,
  parameter int unsigned WE_SETUP_CYC = 2,
  parameter int unsigned WE_HOLD_CYC  = 3,
  parameter int unsigned NORM_LAT     = 3,
  parameter int unsigned TEST_EXTRA   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              dq_o,
  output logic              dq_oe_o,
  output logic              test_active_o
);
  logic ras_fall, cas_acc, active, rd_bit, grp_eq;

  dram_ptest_strobe_dec #(
    .WE_SETUP_CYC(WE_SETUP_CYC),
    .WE_HOLD_CYC (WE_HOLD_CYC)
  ) i_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ras_n_i      (ras_n_i),
    .cas_n_i      (cas_n_i),
    .we_n_i       (we_n_i),
    .ras_fall_o   (ras_fall),
    .cas_acc_o    (cas_acc),
    .test_active_o(active)
  );

  dram_ptest_store #(
    .ADDR_W  (ADDR_W),
    .ROW_BITS(ROW_BITS),
    .COL_LO  (COL_LO)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .row_ld_i(ras_fall),
    .col_ld_i(cas_acc),
    .wr_en_i (cas_acc & ~we_n_i),
    .wr_all_i(active),
    .din_i   (din_i),
    .rd_bit_o(rd_bit),
    .grp_eq_o(grp_eq)
  );

  dram_ptest_rd_pipe #(
    .NORM_LAT  (NORM_LAT),
    .TEST_EXTRA(TEST_EXTRA)
  ) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cas_n_i (cas_n_i),
    .start_i (cas_acc & we_n_i),
    .test_i  (active),
    .rd_bit_i(rd_bit),
    .grp_eq_i(grp_eq),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  assign test_active_o = active;
endmodule

// File: tb/test_dram_ptest_top.sv
module test_dram_ptest_top;
  localparam int NLAT = 3;
  localparam int TLAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [10:0] addr = '0;
  logic dq, dq_oe, tact;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_ptest_top i_dram_ptest_top (
    .clk_i(clk), .rst_ni(rst_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .addr_i(addr), .din_i(din), .dq_o(dq), .dq_oe_o(dq_oe), .test_active_o(tact)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] row, input logic [10:0] col, input logic d);
    addr = 11'(row); ras_n = 1'b0;
    @(negedge clk);
    addr = col; we_n = 1'b0; din = d; cas_n = 1'b0;
    @(negedge clk);
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    ras_n = 1'b1;
    idle(2);
  endtask

  task automatic do_read(input string req, input logic [1:0] row, input logic [10:0] col,
                         input int lat, input logic exp);
    addr = 11'(row); ras_n = 1'b0;
    @(negedge clk);
    addr = col; cas_n = 1'b0;
    idle(lat);
    chk({req, " oe before latency"}, dq_oe, 1'b0);
    @(negedge clk);
    chk({req, " oe at latency"}, dq_oe, 1'b1);
    chk({req, " data"}, dq, exp);
    cas_n = 1'b1;
    @(negedge clk);
    chk("R12 oe off after cas high", dq_oe, 1'b0);
    ras_n = 1'b1;
    idle(2);
  endtask

  task automatic enter(input int setup, input int hold);
    we_n = 1'b0; cas_n = 1'b0;
    idle(setup);
    ras_n = 1'b0;
    idle(hold);
    we_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1;
    idle(2);
  endtask

  task automatic cbr_exit();
    cas_n = 1'b0;
    @(negedge clk);
    ras_n = 1'b0;
    idle(2);
    ras_n = 1'b1; cas_n = 1'b1;
    idle(2);
  endtask

  task automatic ras_only(input logic [1:0] row);
    addr = 11'(row); ras_n = 1'b0;
    idle(3);
    ras_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 test_active after reset", tact, 1'b0);
    chk("R1 dq_oe after reset", dq_oe, 1'b0);
  endtask

  task automatic t_normal();
    do_write(2'd1, 11'h005, 1'b1);
    do_read("R8 normal read", 2'd1, 11'h005, NLAT, 1'b1);
    do_read("R8 neighbour read", 2'd1, 11'h004, NLAT, 1'b0);
  endtask

  task automatic t_test_write_read();
    enter(2, 4);
    chk("R2 entry sets test_active", tact, 1'b1);
    do_write(2'd2, 11'h004, 1'b1);
    chk("R5 held after write", tact, 1'b1);
    do_read("R9 R11 test read equal, CA bits ignored", 2'd2, 11'h407, TLAT, 1'b1);
    chk("R5 held after read", tact, 1'b1);
    cbr_exit();
    chk("R6 cbr exit clears", tact, 1'b0);
    for (int g = 0; g < 8; g++) begin
      logic [10:0] c;
      c = {g[2], 6'd0, 2'b01, g[1:0]};
      do_read("R10 group member", 2'd2, c, NLAT, 1'b1);
    end
    do_read("R10 other group untouched", 2'd2, 11'h008, NLAT, 1'b0);
  endtask

  task automatic t_mismatch();
    do_write(2'd2, 11'h405, 1'b0);
    enter(2, 4);
    chk("R2 re-entry", tact, 1'b1);
    do_read("R11 test read unequal", 2'd2, 11'h004, TLAT, 1'b0);
    ras_only(2'd3);
    chk("R7 ras-only exit clears", tact, 1'b0);
  endtask

  task automatic t_bad_timing();
    enter(1, 4);
    chk("R3 short setup rejected", tact, 1'b0);
    enter(2, 1);
    chk("R4 short hold rejected", tact, 1'b0);
    enter(3, 5);
    chk("R2 long setup accepted", tact, 1'b1);
    cbr_exit();
    chk("R6 exit again", tact, 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_normal();
    t_test_write_read();
    t_mismatch();
    t_bad_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule